// File: doc/BRIEF.md
# Fetch Target Predictor

This block chooses the address to fetch after the current instruction, one instruction per cycle. The fetch stage presents the program counter with three class flags: the instruction is an unconditional transfer, a return, or a call. The block also receives the entry currently at the top of an external return-address stack. It holds a table of 2-bit direction counters and a tagged branch target buffer. It returns a taken/not-taken prediction and the next fetch address, and it issues push and pop requests to the return stack.

A conditional instruction is predicted taken only when its direction counter says so. An unconditional one is always treated as taken. A taken return takes its target from the return stack and does not look at the target buffer. Any other taken instruction needs a target buffer hit. On a miss it falls back to not-taken and to the sequential address. A taken call pushes its return address before that lookup, so the push happens whether the lookup hits or misses. A separate update port trains the counters and writes target entries once branches resolve. Five event counters record how often each path is used.

Top module: `fetch_tgt_pred`

## Requirements
- R1: After reset, out_valid, pred_taken, ras_push, ras_pop, next_pc and all five event counters are 0. Every direction counter holds weakly-not-taken (01). Every target buffer entry is invalid.
- R2: An instruction with is_uncond=1 is treated as taken regardless of its counter. An instruction with is_uncond=0 is treated as taken only when bit 1 of its direction counter is 1.
- R3: A taken return (is_return=1) gives pred_taken=1, next_pc=ras_top and ras_pop=1, whatever the target buffer holds. A return that is not taken does not pop.
- R4: A taken non-return call (is_call=1) raises ras_push with ras_push_addr = pc+4, whether the target buffer hits or misses. ras_push and ras_pop are never high together.
- R5: A taken non-return instruction that hits in the target buffer gives pred_taken=1 and next_pc = the stored target. On a miss, or when the instruction is not taken, it gives pred_taken=0 and next_pc = pc+4.
- R6: The table index is pc[7:2]. The stored tag is pc[15:8]. A valid entry whose tag differs from the looked-up pc is a miss.
- R7: upd_valid with upd_taken=1 increments the counter at upd_pc[7:2], saturating at 3. With upd_taken=0 it decrements the counter, saturating at 0. upd_tgt_we writes the entry at upd_pc[7:2] as valid with tag upd_pc[15:8] and target upd_target.
- R8: Results are registered. They appear with out_valid=1 in the cycle after fetch_valid=1. A cycle with fetch_valid=0 gives out_valid=0, pred_taken=0, ras_push=0 and ras_pop=0 in the next cycle.
- R9: For each valid lookup, the event counters are updated as follows:
  - lookups increments.
  - cond increments when is_uncond=0.
  - tgt_lookups increments for a taken non-return.
  - tgt_hits increments for a taken non-return that hits.
  - ras_used increments for a taken return.
- R10: A lookup and an update in the same cycle to the same entry use the table contents from before the update. The update takes effect from the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid_i | input | 1 | A lookup is presented this cycle |
| pc_i | input | 32 | Address of the instruction |
| is_uncond_i | input | 1 | Unconditional control transfer |
| is_return_i | input | 1 | Instruction is a return |
| is_call_i | input | 1 | Instruction is a call |
| ras_top_i | input | 32 | Current top of the return stack |
| upd_valid_i | input | 1 | Train the direction counter |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction |
| upd_tgt_we_i | input | 1 | Write the target buffer entry |
| upd_target_i | input | 32 | Resolved target address |
| out_valid_o | output | 1 | Prediction outputs are valid |
| pred_taken_o | output | 1 | Predicted taken |
| next_pc_o | output | 32 | Next fetch address |
| ras_push_o | output | 1 | Push request to the return stack |
| ras_push_addr_o | output | 32 | Address to push |
| ras_pop_o | output | 1 | Pop request to the return stack |
| cnt_lookups_o | output | 16 | Lookup count |
| cnt_cond_o | output | 16 | Conditional prediction count |
| cnt_tgt_lookups_o | output | 16 | Target buffer lookup count |
| cnt_tgt_hits_o | output | 16 | Target buffer hit count |
| cnt_ras_used_o | output | 16 | Return stack use count |

## Verification
Some properties are checked by assertions on every cycle:
- push and pop are mutually exclusive;
- a pop always comes with the return-stack value as next address;
- a push address is always the sequential address;
- a not-taken result always falls through;
- idle cycles stay quiet;
- the lookup counter steps once per valid result.

Other behaviour depends on table contents, so only the bench's scenarios can show it. This covers:
- the counter saturation sequences;
- the tag-alias miss;
- the downgrade of a taken call on a miss;
- the read-before-write ordering when a lookup and an update meet.

The bench's behavioural model covers these scenarios.

// File: rtl/fetch_tgt_pkg.sv
package fetch_tgt_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_e;

    function automatic ctr_e ctr_step(ctr_e cur, logic taken);
        if (taken)
            return (cur == CTR_ST) ? CTR_ST : ctr_e'(cur + 2'd1);
        else
            return (cur == CTR_SNT) ? CTR_SNT : ctr_e'(cur - 2'd1);
    endfunction

endpackage

// File: rtl/dir_counter_table.sv
module dir_counter_table
    import fetch_tgt_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    ctr_e ctr_q [ENTRIES];
    ctr_e ctr_d [ENTRIES];

    assign rd_taken = (ctr_q[rd_idx] == CTR_WT) || (ctr_q[rd_idx] == CTR_ST);

    always_comb begin
        ctr_d = ctr_q;
        if (wr_en)
            ctr_d[wr_idx] = ctr_step(ctr_q[wr_idx], wr_taken);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
                ctr_q[i] <= CTR_WNT;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    // R7: a written counter moves by at most one step in the written direction
    p_ctr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && ctr_q[wr_idx] != CTR_ST) |=> (ctr_q[$past(wr_idx)] == ctr_e'($past(ctr_q[wr_idx]) + 2'd1)));

endmodule

// File: rtl/target_buffer.sv
module target_buffer #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 8,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target
);

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] tgt;
    } entry_t;

    entry_t ent_q [ENTRIES];
    entry_t ent_d [ENTRIES];

    assign rd_hit    = ent_q[rd_idx].vld && (ent_q[rd_idx].tag == rd_tag);
    assign rd_target = ent_q[rd_idx].tgt;

    always_comb begin
        ent_d = ent_q;
        if (wr_en)
            ent_d[wr_idx] = '{vld: 1'b1, tag: wr_tag, tgt: wr_target};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
                ent_q[i] <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    // R7: a write leaves its entry valid on the next cycle
    p_write_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_q[$past(wr_idx)].vld);

endmodule

// File: rtl/fetch_tgt_pred.sv
module fetch_tgt_pred #(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 64,
    parameter int TAG_W      = 8,
    parameter int INST_BYTES = 4,
    parameter int CNT_W      = 16,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int SHIFT     = $clog2(INST_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              is_uncond_i,
    input  logic              is_return_i,
    input  logic              is_call_i,
    input  logic [ADDR_W-1:0] ras_top_i,
    input  logic              upd_valid_i,
    input  logic [ADDR_W-1:0] upd_pc_i,
    input  logic              upd_taken_i,
    input  logic              upd_tgt_we_i,
    input  logic [ADDR_W-1:0] upd_target_i,
    output logic              out_valid_o,
    output logic              pred_taken_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              ras_push_o,
    output logic [ADDR_W-1:0] ras_push_addr_o,
    output logic              ras_pop_o,
    output logic [CNT_W-1:0]  cnt_lookups_o,
    output logic [CNT_W-1:0]  cnt_cond_o,
    output logic [CNT_W-1:0]  cnt_tgt_lookups_o,
    output logic [CNT_W-1:0]  cnt_tgt_hits_o,
    output logic [CNT_W-1:0]  cnt_ras_used_o
);

    typedef struct packed {
        logic              vld;
        logic              taken;
        logic [ADDR_W-1:0] npc;
        logic              push;
        logic [ADDR_W-1:0] push_addr;
        logic              pop;
        logic [CNT_W-1:0]  c_look;
        logic [CNT_W-1:0]  c_cond;
        logic [CNT_W-1:0]  c_tlook;
        logic [CNT_W-1:0]  c_thit;
        logic [CNT_W-1:0]  c_ras;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [TAG_W-1:0]  rd_tag, wr_tag;
    logic              dir_taken, tb_hit;
    logic [ADDR_W-1:0] tb_target, seq_pc;
    logic              unused_upd_bits;

    assign rd_idx = pc_i[SHIFT +: IDX_W];
    assign rd_tag = pc_i[SHIFT + IDX_W +: TAG_W];
    assign wr_idx = upd_pc_i[SHIFT +: IDX_W];
    assign wr_tag = upd_pc_i[SHIFT + IDX_W +: TAG_W];
    assign seq_pc = pc_i + ADDR_W'(INST_BYTES);
    assign unused_upd_bits = ^upd_pc_i;

    dir_counter_table #(.ENTRIES(ENTRIES)) i_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_taken (dir_taken),
        .wr_en    (upd_valid_i),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken_i)
    );

    target_buffer #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) i_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_idx),
        .rd_tag    (rd_tag),
        .rd_hit    (tb_hit),
        .rd_target (tb_target),
        .wr_en     (upd_tgt_we_i),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_target (upd_target_i)
    );

    always_comb begin
        logic dir;
        st_d       = st_q;
        st_d.vld   = fetch_valid_i;
        st_d.taken = 1'b0;
        st_d.push  = 1'b0;
        st_d.pop   = 1'b0;
        dir        = is_uncond_i || dir_taken;
        if (fetch_valid_i) begin
            st_d.npc    = seq_pc;
            st_d.c_look = st_q.c_look + 1'b1;
            if (!is_uncond_i)
                st_d.c_cond = st_q.c_cond + 1'b1;
            if (dir && is_return_i) begin
                st_d.taken = 1'b1;
                st_d.npc   = ras_top_i;
                st_d.pop   = 1'b1;
                st_d.c_ras = st_q.c_ras + 1'b1;
            end else if (dir) begin
                st_d.c_tlook = st_q.c_tlook + 1'b1;
                if (is_call_i) begin
                    st_d.push      = 1'b1;
                    st_d.push_addr = seq_pc;
                end
                if (tb_hit) begin
                    st_d.taken  = 1'b1;
                    st_d.npc    = tb_target;
                    st_d.c_thit = st_q.c_thit + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o       = st_q.vld;
    assign pred_taken_o      = st_q.taken;
    assign next_pc_o         = st_q.npc;
    assign ras_push_o        = st_q.push;
    assign ras_push_addr_o   = st_q.push_addr;
    assign ras_pop_o         = st_q.pop;
    assign cnt_lookups_o     = st_q.c_look;
    assign cnt_cond_o        = st_q.c_cond;
    assign cnt_tgt_lookups_o = st_q.c_tlook;
    assign cnt_tgt_hits_o    = st_q.c_thit;
    assign cnt_ras_used_o    = st_q.c_ras;

    p_pop_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ras_pop_o |-> (pred_taken_o && next_pc_o == $past(ras_top_i)));

    p_push_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ras_push_o |-> (ras_push_addr_o == $past(pc_i) + ADDR_W'(INST_BYTES)));

    p_push_pop_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ras_push_o && ras_pop_o));

    p_fallthrough_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !pred_taken_o) |-> (next_pc_o == $past(pc_i) + ADDR_W'(INST_BYTES)));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (!pred_taken_o && !ras_push_o && !ras_pop_o));

    p_lookup_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (cnt_lookups_o == $past(cnt_lookups_o) + 1'b1));

endmodule

// File: tb/test_fetch_tgt_pred.sv
module test_fetch_tgt_pred;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic        is_uncond_i = 1'b0, is_return_i = 1'b0, is_call_i = 1'b0;
    logic [31:0] ras_top_i = '0;
    logic        upd_valid_i = 1'b0, upd_taken_i = 1'b0, upd_tgt_we_i = 1'b0;
    logic [31:0] upd_pc_i = '0, upd_target_i = '0;
    logic        out_valid_o, pred_taken_o, ras_push_o, ras_pop_o;
    logic [31:0] next_pc_o, ras_push_addr_o;
    logic [15:0] cnt_lookups_o, cnt_cond_o, cnt_tgt_lookups_o, cnt_tgt_hits_o, cnt_ras_used_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int unsigned m_ctr [64];
    bit          m_v   [64];
    int unsigned m_tag [64];
    logic [31:0] m_tgt [64];
    int unsigned e_look = 0, e_cond = 0, e_tl = 0, e_th = 0, e_ras = 0;

    always #5 clk = ~clk;

    fetch_tgt_pred i_fetch_tgt_pred (
        .clk(clk), .rst_n(rst_n), .fetch_valid_i(fetch_valid_i), .pc_i(pc_i),
        .is_uncond_i(is_uncond_i), .is_return_i(is_return_i), .is_call_i(is_call_i),
        .ras_top_i(ras_top_i), .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i),
        .upd_taken_i(upd_taken_i), .upd_tgt_we_i(upd_tgt_we_i), .upd_target_i(upd_target_i),
        .out_valid_o(out_valid_o), .pred_taken_o(pred_taken_o), .next_pc_o(next_pc_o),
        .ras_push_o(ras_push_o), .ras_push_addr_o(ras_push_addr_o), .ras_pop_o(ras_pop_o),
        .cnt_lookups_o(cnt_lookups_o), .cnt_cond_o(cnt_cond_o),
        .cnt_tgt_lookups_o(cnt_tgt_lookups_o), .cnt_tgt_hits_o(cnt_tgt_hits_o),
        .cnt_ras_used_o(cnt_ras_used_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One cycle: drive at negedge, predict from model, update model at edge, compare after edge
    task automatic step(input bit fv, input logic [31:0] pc, input bit u, input bit r, input bit c,
                        input logic [31:0] rt, input bit uv, input logic [31:0] upc, input bit ut,
                        input bit twe, input logic [31:0] ttgt, input string req);
        int unsigned idx, tg, ui;
        bit dir, e_t, e_push, e_pop;
        logic [31:0] e_np, e_pa;
        @(negedge clk);
        fetch_valid_i = fv; pc_i = pc; is_uncond_i = u; is_return_i = r; is_call_i = c;
        ras_top_i = rt; upd_valid_i = uv; upd_pc_i = upc; upd_taken_i = ut;
        upd_tgt_we_i = twe; upd_target_i = ttgt;
        idx = (pc >> 2) & 63; tg = (pc >> 8) & 255;
        dir = u || (m_ctr[idx] >= 2);
        e_t = 0; e_push = 0; e_pop = 0; e_np = pc + 4; e_pa = pc + 4;
        if (fv) begin
            e_look++;
            if (!u) e_cond++;
            if (dir && r) begin
                e_t = 1; e_np = rt; e_pop = 1; e_ras++;
            end else if (dir) begin
                e_tl++;
                if (c) e_push = 1;
                if (m_v[idx] && m_tag[idx] == tg) begin
                    e_th++; e_t = 1; e_np = m_tgt[idx];
                end
            end
        end
        @(posedge clk);
        ui = (upc >> 2) & 63;
        if (uv) begin
            if (ut && m_ctr[ui] < 3) m_ctr[ui]++;
            if (!ut && m_ctr[ui] > 0) m_ctr[ui]--;
        end
        if (twe) begin
            m_v[ui] = 1; m_tag[ui] = (upc >> 8) & 255; m_tgt[ui] = ttgt;
        end
        #1;
        chk("R8", "out_valid", {31'd0, out_valid_o}, {31'd0, fv});
        chk(req, "pred_taken", {31'd0, pred_taken_o}, {31'd0, e_t});
        chk(req, "ras_push", {31'd0, ras_push_o}, {31'd0, e_push});
        chk(req, "ras_pop", {31'd0, ras_pop_o}, {31'd0, e_pop});
        if (fv) chk(req, "next_pc", next_pc_o, e_np);
        if (e_push) chk("R4", "push_addr", ras_push_addr_o, e_pa);
        chk("R9", "cnt_lookups", {16'd0, cnt_lookups_o}, e_look & 32'hFFFF);
        chk("R9", "cnt_cond", {16'd0, cnt_cond_o}, e_cond & 32'hFFFF);
        chk("R9", "cnt_tgt_lookups", {16'd0, cnt_tgt_lookups_o}, e_tl & 32'hFFFF);
        chk("R9", "cnt_tgt_hits", {16'd0, cnt_tgt_hits_o}, e_th & 32'hFFFF);
        chk("R9", "cnt_ras_used", {16'd0, cnt_ras_used_o}, e_ras & 32'hFFFF);
    endtask

    task automatic look(input logic [31:0] pc, input bit u, input bit r, input bit c,
                        input logic [31:0] rt, input string req);
        step(1, pc, u, r, c, rt, 0, 0, 0, 0, 0, req);
    endtask

    task automatic train(input logic [31:0] upc, input bit ut, input string req);
        step(0, 0, 0, 0, 0, 0, 1, upc, ut, 0, 0, req);
    endtask

    task automatic write_tgt(input logic [31:0] upc, input logic [31:0] tgt, input string req);
        step(0, 0, 0, 0, 0, 0, 0, upc, 0, 1, tgt, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_ctr[i] = 1; m_v[i] = 0; m_tag[i] = 0; m_tgt[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "out_valid", {31'd0, out_valid_o}, 0);
        chk("R1", "pred_taken", {31'd0, pred_taken_o}, 0);
        chk("R1", "push", {31'd0, ras_push_o}, 0);
        chk("R1", "pop", {31'd0, ras_pop_o}, 0);
        chk("R1", "next_pc", next_pc_o, 0);
        chk("R1", "cnt_lookups", {16'd0, cnt_lookups_o}, 0);
        chk("R1", "cnt_ras_used", {16'd0, cnt_ras_used_o}, 0);
        // R1: fresh counter is weakly not-taken, fresh buffer invalid
        look(32'h0000_1010, 0, 0, 0, 0, "R1");
        look(32'h0000_1014, 1, 0, 0, 0, "R1");
        // R8: idle cycle
        step(0, 32'h0000_2000, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R7 / R2: train up 01 -> 10: now conditional direction is taken, but miss downgrades (R5)
        train(32'h0000_1010, 1, "R7");
        look(32'h0000_1010, 0, 0, 0, 0, "R5");
        write_tgt(32'h0000_1010, 32'h0000_8000, "R7");
        look(32'h0000_1010, 0, 0, 0, 0, "R5");
        // R6: same index, different tag -> miss
        look(32'h0000_1110, 1, 0, 0, 0, "R6");
        // R2: unconditional hit uses the buffer even with counter not-taken
        write_tgt(32'h0000_3020, 32'h0000_9000, "R7");
        look(32'h0000_3020, 1, 0, 0, 0, "R2");
        look(32'h0000_3020, 0, 0, 0, 0, "R2");
        // R4: taken call on a miss still pushes, falls through
        look(32'h0000_4040, 1, 0, 1, 0, "R4");
        // R4: taken call on a hit pushes and redirects
        write_tgt(32'h0000_4040, 32'h0000_A000, "R7");
        look(32'h0000_4040, 1, 0, 1, 0, "R4");
        // R3: return ignores the buffer entry at its pc
        look(32'h0000_4040, 1, 1, 0, 32'h0000_5554, "R3");
        // R3: conditional return with not-taken counter does not pop
        look(32'h0000_6060, 0, 1, 0, 32'h0000_7770, "R3");
        // R7: saturate up then one down stays taken
        for (int k = 0; k < 5; k++) train(32'h0000_0080, 1, "R7");
        train(32'h0000_0080, 0, "R7");
        write_tgt(32'h0000_0080, 32'h0000_0C00, "R7");
        look(32'h0000_0080, 0, 0, 0, 0, "R7");
        // R7: saturate down then one up stays not-taken
        for (int k = 0; k < 5; k++) train(32'h0000_0080, 0, "R7");
        train(32'h0000_0080, 1, "R7");
        look(32'h0000_0080, 0, 0, 0, 0, "R7");
        // R10: lookup sees old counter (01), update to 10 applies next
        step(1, 32'h0000_0080, 0, 0, 0, 0, 1, 32'h0000_0080, 1, 0, 0, "R10");
        look(32'h0000_0080, 0, 0, 0, 0, "R10");
        // R10: target write in the same cycle as a lookup
        step(1, 32'h0000_00C0, 1, 0, 0, 0, 0, 32'h0000_00C0, 0, 1, 32'h0000_0D00, "R10");
        look(32'h0000_00C0, 1, 0, 0, 0, "R10");
        // Mixed traffic against the model
        for (int n = 0; n < 400; n++) begin
            logic [31:0] p, q;
            p = 32'h0000_1000 + (($urandom % 16) << 2) + (($urandom % 2) << 8);
            q = 32'h0000_1000 + (($urandom % 16) << 2) + (($urandom % 2) << 8);
            step($urandom % 4 != 0, p, $urandom % 3 == 0, $urandom % 5 == 0, $urandom % 4 == 0,
                 $urandom, $urandom % 2 == 0, q, $urandom % 2 == 0, $urandom % 6 == 0,
                 32'h0002_0000 + ($urandom % 256) * 4, "R5");
        end
        summary();
    end

endmodule